// File: doc/BRIEF.md
# Planar Display Memory Write Datapath

This block sits between a processor's byte-wide memory accesses and four byte-wide display planes that share one address. A write does not simply store the processor's byte. It goes through a per-plane pipeline: rotate, set/reset substitution, a logical function against the plane's latch, a per-bit merge under a bit mask, and a plane-enable mask. Four write modes pick which of these stages take part.

A read returns one plane's byte and refreshes all four latches from the addressed location. Later writes combine with those latches, which is how plane-to-plane copies and read-modify-write effects are done. Two address mappings are offered for writes, linear or odd/even steering, and two for reads, plane-select or chain-4. Both are taken relative to a fixed window base, and the offset wraps at the smaller of the window size and the plane depth.

Each accepted access takes a fixed two-cycle sequence, and `busy` holds off new requests until it ends. The configuration fields are expected to stay stable from a request until its `done` pulse.

Top module: `vgaw_top`

## Requirements
- R1: Reset state. After reset, `busy`, `done` and `rd_data` are 0, and all four latches hold 0x00. A mode-1 write issued before any read therefore stores 0x00.
- R2: Access timing and blocking.
  - A request is accepted on a rising edge where `req` is 1 and `busy` is 0.
  - `busy` is 1 for exactly the one following cycle. `done` is 1 in the cycle after that.
  - Read data and plane updates are visible once `done` is 1.
  - A request present while `busy` is 1 is ignored.
- R3: Write mode 0 (`cfg_write_mode`=0) with set/reset disabled.
  - The byte is first rotated right by `cfg_rotate`.
  - It is then combined with the plane latch under `cfg_func`: 0 passes it through, 1 ANDs, 2 ORs, 3 XORs.
  - The stored byte is (mask & value) | (~mask & latch), where mask is `cfg_bit_mask`.
- R4: Write mode 0 with set/reset. For each plane n whose `cfg_sr_enable[n]` is 1, the rotated byte is replaced by `cfg_set_reset[n]` repeated across all 8 bits, before the function and the merge.
- R5: Write mode 1. Each enabled plane is written with its latch unchanged.
- R6: Write mode 2. Plane n receives bit n of the processor byte repeated across all 8 bits. The function and the bit-mask merge then follow. No rotation is applied.
- R7: Write mode 3. The rotated byte ANDed with `cfg_bit_mask` forms the effective mask. Plane n stores `cfg_set_reset[n]` repeated across 8 bits where that mask is 1, and the latch elsewhere.
- R8: A plane whose `cfg_map_mask` bit is 0 is not written in any write mode.
- R9: Odd/even write steering. With `cfg_seq_linear`=0, the write offset is the relative address shifted right by 1. An even relative address may write only planes 0 and 2 (map mask & 0x5), and an odd one only planes 1 and 3 (map mask & 0xA). With `cfg_seq_linear`=1, the offset is the relative address and the map mask applies unchanged.
- R10: Plane-select read. With `cfg_chain4`=0, the read offset is the relative address and `rd_data` comes from plane `cfg_read_plane`. Every read loads all four latches from the addressed offset.
- R11: Chain-4 read. With `cfg_chain4`=1, the relative address bits [1:0] select the plane and the offset is the relative address shifted right by 2.
- R12: Window mapping. The relative address is `addr` minus `WIN_BASE`. The offset wraps modulo the smaller of `WIN_SIZE` and the plane depth (512 entries by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Processor byte address |
| wdata | input | 8 | Processor write byte |
| cfg_write_mode | input | 2 | Write mode 0..3 |
| cfg_rotate | input | 3 | Right-rotate count |
| cfg_func | input | 2 | 0 pass, 1 AND, 2 OR, 3 XOR with latch |
| cfg_set_reset | input | 4 | Per-plane set/reset bit |
| cfg_sr_enable | input | 4 | Per-plane set/reset enable (mode 0) |
| cfg_bit_mask | input | 8 | Per-bit select: new value vs latch |
| cfg_map_mask | input | 4 | Per-plane write enable |
| cfg_seq_linear | input | 1 | 1 = linear writes, 0 = odd/even steering |
| cfg_chain4 | input | 1 | 1 = chain-4 read addressing |
| cfg_read_plane | input | 2 | Plane returned by a non-chain-4 read |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse after completion |
| rd_data | output | 8 | Byte returned by the last read |

## Verification
An accepted request raises `busy` one edge later. The second edge commits the plane writes or the read data and latches, and the cycle after it shows `done`. The bench drives on falling edges and therefore samples `busy` one falling edge after raising `req`. It samples `rd_data` and `done` on the falling edge after that. Every write result is checked through a later read of each plane, taken once that read's own two-cycle sequence has ended. Latch-dependent results are checked against values computed from the requirements, using latches loaded by a read of a different address.

// File: rtl/vgaw_pkg.sv
// Shared types and helpers for the planar write datapath.
// Assumes exactly four byte-wide planes.
package vgaw_pkg;
    localparam int NPLANES = 4;

    typedef enum logic [1:0] {
        WM_LOGIC  = 2'd0,
        WM_LATCH  = 2'd1,
        WM_SPREAD = 2'd2,
        WM_MASKED = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        FN_PASS = 2'd0,
        FN_AND  = 2'd1,
        FN_OR   = 2'd2,
        FN_XOR  = 2'd3
    } alu_fn_e;

    // Rotate a byte right by n positions.
    function automatic logic [7:0] rotr8(input logic [7:0] d, input logic [2:0] n);
        logic [15:0] t;
        t = {d, d} >> n;
        return t[7:0];
    endfunction

    // Combine a value with a latch byte under the selected function.
    function automatic logic [7:0] alu_apply(input alu_fn_e f, input logic [7:0] d,
                                             input logic [7:0] l);
        case (f)
            FN_AND:  return d & l;
            FN_OR:   return d | l;
            FN_XOR:  return d ^ l;
            default: return d;
        endcase
    endfunction
endpackage

// File: rtl/vgaw_addr_map.sv
// Address mapping: window-relative offset, write plane steering and
// read plane selection. Purely combinational. Assumes WIN_BASE is even
// and both WIN_SIZE and the plane depth are powers of two.
module vgaw_addr_map #(
    parameter int          ADDR_W   = 20,
    parameter int          PLANE_AW = 9,
    parameter int unsigned WIN_BASE = 32'h000A_0000,
    parameter int unsigned WIN_SIZE = 32'h0001_0000
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                is_read,
    input  logic                seq_linear,
    input  logic                chain4,
    input  logic [3:0]          map_mask,
    input  logic [1:0]          read_plane,
    output logic [PLANE_AW-1:0] offset,
    output logic [3:0]          plane_we,
    output logic [1:0]          rd_sel
);
    localparam int unsigned    DEPTH    = 32'd1 << PLANE_AW;
    localparam int unsigned    EFF      = (WIN_SIZE < DEPTH) ? WIN_SIZE : DEPTH;
    localparam logic [PLANE_AW-1:0] EFF_MASK = PLANE_AW'(EFF - 1);
    localparam logic [ADDR_W-1:0]   BASE_A   = ADDR_W'(WIN_BASE);

    logic [ADDR_W-1:0]   rel;
    logic [PLANE_AW-1:0] off_raw;
    logic                addr_unused_hi;

    // Window-relative address.
    assign rel            = addr - BASE_A;
    assign addr_unused_hi = ^rel[ADDR_W-1:PLANE_AW+2];

    // Choose the shift by access type and addressing mode.
    always_comb begin
        if (is_read)
            off_raw = chain4 ? rel[PLANE_AW+1:2] : rel[PLANE_AW-1:0];
        else
            off_raw = seq_linear ? rel[PLANE_AW-1:0] : rel[PLANE_AW:1];
    end

    // Wrap at the effective window size.
    assign offset = off_raw & EFF_MASK;

    // Odd/even steering restricts the writable planes.
    assign plane_we = seq_linear ? map_mask
                    : (rel[0] ? (map_mask & 4'hA) : (map_mask & 4'h5));

    // Plane returned by a read.
    assign rd_sel = chain4 ? rel[1:0] : read_plane;
endmodule

// File: rtl/vgaw_plane_alu.sv
// One plane's write pipeline: set/reset substitution, logical function
// against the latch and bit-mask merge, selected by the write mode.
// The rotated byte arrives already rotated; cpu_bit is bit PLANE_IDX of
// the unrotated processor byte.
module vgaw_plane_alu (
    input  logic [1:0] wmode,
    input  logic       cpu_bit,
    input  logic [7:0] rot_data,
    input  logic       sr_bit,
    input  logic       sre_bit,
    input  logic [1:0] fn,
    input  logic [7:0] bit_mask,
    input  logic [7:0] latch,
    output logic [7:0] result
);
    import vgaw_pkg::*;

    logic [7:0] src;
    logic [7:0] mix;
    logic [7:0] eff;

    // Form the per-plane result for the active write mode.
    always_comb begin
        src    = 8'h00;
        mix    = 8'h00;
        eff    = 8'h00;
        result = latch;
        case (wmode_e'(wmode))
            WM_LOGIC: begin
                src    = sre_bit ? {8{sr_bit}} : rot_data;
                mix    = alu_apply(alu_fn_e'(fn), src, latch);
                result = (bit_mask & mix) | (~bit_mask & latch);
            end
            WM_LATCH: result = latch;
            WM_SPREAD: begin
                src    = {8{cpu_bit}};
                mix    = alu_apply(alu_fn_e'(fn), src, latch);
                result = (bit_mask & mix) | (~bit_mask & latch);
            end
            default: begin
                eff    = rot_data & bit_mask;
                result = (eff & {8{sr_bit}}) | (~eff & latch);
            end
        endcase
    end
endmodule

// File: rtl/vgaw_plane_ram.sv
// One display plane: simple dual-address RAM, synchronous read.
// Contents are not reset.
module vgaw_plane_ram #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Write port and registered read port.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/vgaw_top.sv
// Planar write datapath top. Accepts one byte access at a time.
// Edge 1 captures the request and reads all planes at the offset.
// Edge 2 commits plane writes, or loads the latches and read data.
// Assumes the cfg_* inputs stay stable from request until done.
module vgaw_top #(
    parameter int          ADDR_W   = 20,
    parameter int          PLANE_AW = 9,
    parameter int unsigned WIN_BASE = 32'h000A_0000,
    parameter int unsigned WIN_SIZE = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [1:0]        cfg_write_mode,
    input  logic [2:0]        cfg_rotate,
    input  logic [1:0]        cfg_func,
    input  logic [3:0]        cfg_set_reset,
    input  logic [3:0]        cfg_sr_enable,
    input  logic [7:0]        cfg_bit_mask,
    input  logic [3:0]        cfg_map_mask,
    input  logic              cfg_seq_linear,
    input  logic              cfg_chain4,
    input  logic [1:0]        cfg_read_plane,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rd_data
);
    import vgaw_pkg::*;

    logic [PLANE_AW-1:0] map_off, off_q;
    logic [3:0]          map_we, we_mask_q, ram_we;
    logic [1:0]          map_sel, sel_q;
    logic                busy_q, done_q, op_wr_q, accept;
    logic [7:0]          data_q, rd_data_q, rot_data;
    logic [7:0]          latch_q [NPLANES];
    logic [7:0]          ram_q   [NPLANES];
    logic [7:0]          alu_res [NPLANES];

    assign accept = req & ~busy_q;

    vgaw_addr_map #(
        .ADDR_W(ADDR_W), .PLANE_AW(PLANE_AW),
        .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
    ) u_map (
        .addr(addr), .is_read(~req_write), .seq_linear(cfg_seq_linear),
        .chain4(cfg_chain4), .map_mask(cfg_map_mask), .read_plane(cfg_read_plane),
        .offset(map_off), .plane_we(map_we), .rd_sel(map_sel)
    );

    assign rot_data = rotr8(data_q, cfg_rotate);

    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        vgaw_plane_alu u_alu (
            .wmode(cfg_write_mode), .cpu_bit(data_q[p]), .rot_data(rot_data),
            .sr_bit(cfg_set_reset[p]), .sre_bit(cfg_sr_enable[p]), .fn(cfg_func),
            .bit_mask(cfg_bit_mask), .latch(latch_q[p]), .result(alu_res[p])
        );

        assign ram_we[p] = busy_q & op_wr_q & we_mask_q[p];

        vgaw_plane_ram #(.AW(PLANE_AW)) u_ram (
            .clk(clk), .we(ram_we[p]), .waddr(off_q), .wdata(alu_res[p]),
            .raddr(map_off), .rdata(ram_q[p])
        );
    end

    // Request capture and the two-cycle busy sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            op_wr_q   <= 1'b0;
            data_q    <= 8'h00;
            off_q     <= '0;
            we_mask_q <= 4'h0;
            sel_q     <= 2'd0;
        end else begin
            done_q <= busy_q;
            if (accept) begin
                busy_q    <= 1'b1;
                op_wr_q   <= req_write;
                data_q    <= wdata;
                off_q     <= map_off;
                we_mask_q <= map_we;
                sel_q     <= map_sel;
            end else if (busy_q) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Read completion: load every latch and the returned byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPLANES; p++) latch_q[p] <= 8'h00;
            rd_data_q <= 8'h00;
        end else if (busy_q && !op_wr_q) begin
            for (int p = 0; p < NPLANES; p++) latch_q[p] <= ram_q[p];
            rd_data_q <= ram_q[sel_q];
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rd_data = rd_data_q;

    // R2: accepted request is followed by busy
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);
    // R2: busy lasts a single cycle
    a_r2_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R2: completion pulse follows busy
    a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> done);
    // R8: no plane outside the map mask is ever written
    a_r8_we_in_map_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && op_wr_q) |-> ((ram_we & ~cfg_map_mask) == 4'h0));
    // R9: odd/even steering keeps writes on the matching plane pair
    a_r9_odd_even_steer: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && !cfg_seq_linear) |=>
        ((we_mask_q & ($past(addr[0]) ? 4'h5 : 4'hA)) == 4'h0));
    // R10: returned byte agrees with the latch of the selected plane
    a_r10_rd_matches_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_wr_q) |-> (rd_data == latch_q[sel_q]));
endmodule

// File: tb/vgaw_top_tb_top.sv
module vgaw_top_tb_top;
    localparam int          ADDR_W = 20;
    localparam logic [19:0] BASE   = 20'hA0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_write = 1'b0;
    logic [19:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [1:0]  cfg_write_mode = '0, cfg_func = '0, cfg_read_plane = '0;
    logic [2:0]  cfg_rotate = '0;
    logic [3:0]  cfg_set_reset = '0, cfg_sr_enable = '0, cfg_map_mask = 4'hF;
    logic [7:0]  cfg_bit_mask = 8'hFF;
    logic        cfg_seq_linear = 1'b1, cfg_chain4 = 1'b0;
    logic        busy, done;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vgaw_top #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .addr(addr),
        .wdata(wdata), .cfg_write_mode(cfg_write_mode), .cfg_rotate(cfg_rotate),
        .cfg_func(cfg_func), .cfg_set_reset(cfg_set_reset), .cfg_sr_enable(cfg_sr_enable),
        .cfg_bit_mask(cfg_bit_mask), .cfg_map_mask(cfg_map_mask),
        .cfg_seq_linear(cfg_seq_linear), .cfg_chain4(cfg_chain4),
        .cfg_read_plane(cfg_read_plane), .busy(busy), .done(done), .rd_data(rd_data)
    );

    // Vector: mode[34:33] rot[32:30] fn[29:28] sr[27:24] esr[23:20] bm[19:12] mm[11:8] data[7:0]
    localparam logic [34:0] VECS [8] = '{
        {2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h5A},
        {2'd0, 3'd3, 2'd1, 4'h0, 4'h0, 8'hF0, 4'hF, 8'h96},
        {2'd0, 3'd1, 2'd2, 4'h0, 4'h0, 8'h3C, 4'h5, 8'h81},
        {2'd0, 3'd0, 2'd3, 4'hA, 4'h6, 8'hFF, 4'hF, 8'hC3},
        {2'd1, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hB, 8'h77},
        {2'd2, 3'd5, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h05},
        {2'd2, 3'd0, 2'd3, 4'h0, 4'h0, 8'h0F, 4'hF, 8'h0A},
        {2'd3, 3'd2, 2'd0, 4'h9, 4'h0, 8'h7E, 4'hF, 8'hF3}
    };
    localparam logic [7:0] LAT [4] = '{8'h3C, 8'hA5, 8'h0F, 8'hF0};
    localparam logic [7:0] PRE [4] = '{8'h11, 8'h22, 8'h44, 8'h88};

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic cfg_default();
        cfg_write_mode = 2'd0; cfg_rotate = 3'd0; cfg_func = 2'd0;
        cfg_set_reset = 4'h0; cfg_sr_enable = 4'h0; cfg_bit_mask = 8'hFF;
        cfg_map_mask = 4'hF; cfg_seq_linear = 1'b1; cfg_chain4 = 1'b0;
        cfg_read_plane = 2'd0;
    endtask

    // One access: request on a falling edge, result sampled two falling edges later.
    task automatic access(input logic wr, input logic [19:0] a, input logic [7:0] d,
                          output logic [7:0] rd);
        @(negedge clk);
        req = 1'b1; req_write = wr; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        rd = rd_data;
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        access(1'b1, a, d, dummy);
    endtask

    task automatic rd_plane(input logic [19:0] a, input logic [1:0] p, output logic [7:0] v);
        cfg_read_plane = p;
        access(1'b0, a, 8'h00, v);
    endtask

    task automatic load_planes(input logic [19:0] a, input logic [7:0] b0, input logic [7:0] b1,
                               input logic [7:0] b2, input logic [7:0] b3);
        cfg_default();
        cfg_map_mask = 4'h1; wr(a, b0);
        cfg_map_mask = 4'h2; wr(a, b1);
        cfg_map_mask = 4'h4; wr(a, b2);
        cfg_map_mask = 4'h8; wr(a, b3);
        cfg_map_mask = 4'hF;
    endtask

    // Expected plane byte, computed from the requirements.
    function automatic logic [7:0] model(input logic [1:0] m, input logic [2:0] r,
            input logic [1:0] f, input logic [3:0] sr, input logic [3:0] esr,
            input logic [7:0] bm, input logic [7:0] d, input logic [7:0] l, input int p);
        logic [7:0] rot, t, em;
        for (int i = 0; i < 8; i++) rot[i] = d[(i + int'(r)) % 8];
        case (m)
            2'd1: return l;
            2'd3: begin
                em = rot & bm;
                return (em & {8{sr[p]}}) | (~em & l);
            end
            default: begin
                if (m == 2'd2) t = {8{d[p]}};
                else t = esr[p] ? {8{sr[p]}} : rot;
                if (f == 2'd1) t = t & l;
                else if (f == 2'd2) t = t | l;
                else if (f == 2'd3) t = t ^ l;
                return (bm & t) | (~bm & l);
            end
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [19:0] la, ta;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", {7'd0, busy}, 8'h00);
        chk("R1 done", {7'd0, done}, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
        // R1/R5: latches start at zero, copied by a mode-1 write
        load_planes(BASE + 20'h30, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        cfg_write_mode = 2'd1;
        wr(BASE + 20'h30, 8'hAB);
        cfg_default();
        for (int p = 0; p < 4; p++) begin
            rd_plane(BASE + 20'h30, 2'(p), v);
            chk("R1 latch reset", v, 8'h00);
        end

        // R3..R8: table of write vectors; latch from la, target ta
        la = BASE + 20'h10;
        ta = BASE + 20'h20;
        for (int k = 0; k < 8; k++) begin
            load_planes(la, LAT[0], LAT[1], LAT[2], LAT[3]);
            load_planes(ta, PRE[0], PRE[1], PRE[2], PRE[3]);
            rd_plane(la, 2'd0, v);
            cfg_write_mode = VECS[k][34:33]; cfg_rotate = VECS[k][32:30];
            cfg_func = VECS[k][29:28]; cfg_set_reset = VECS[k][27:24];
            cfg_sr_enable = VECS[k][23:20]; cfg_bit_mask = VECS[k][19:12];
            cfg_map_mask = VECS[k][11:8];
            wr(ta, VECS[k][7:0]);
            cfg_default();
            for (int p = 0; p < 4; p++) begin
                rd_plane(ta, 2'(p), v);
                if (!VECS[k][8 + p]) begin
                    tag = "R8 masked plane";
                    chk(tag, v, PRE[p]);
                end else begin
                    case (VECS[k][34:33])
                        2'd0: tag = (VECS[k][20 + p]) ? "R4 set/reset" : "R3 mode0";
                        2'd1: tag = "R5 mode1";
                        2'd2: tag = "R6 mode2";
                        default: tag = "R7 mode3";
                    endcase
                    chk(tag, v, model(VECS[k][34:33], VECS[k][32:30], VECS[k][29:28],
                        VECS[k][27:24], VECS[k][23:20], VECS[k][19:12], VECS[k][7:0], LAT[p], p));
                end
            end
        end

        // R2: busy timing and a request held during busy is ignored
        load_planes(BASE + 20'h40, 8'h42, 8'h42, 8'h42, 8'h42);
        @(negedge clk);
        req = 1'b1; req_write = 1'b1; addr = BASE + 20'h41; wdata = 8'h11;
        @(negedge clk);
        chk("R2 busy after accept", {7'd0, busy}, 8'h01);
        addr = BASE + 20'h40; wdata = 8'h99;
        @(negedge clk);
        req = 1'b0;
        chk("R2 busy single cycle", {7'd0, busy}, 8'h00);
        chk("R2 done pulse", {7'd0, done}, 8'h01);
        rd_plane(BASE + 20'h40, 2'd0, v);
        chk("R2 request during busy ignored", v, 8'h42);
        rd_plane(BASE + 20'h41, 2'd3, v);
        chk("R2 accepted write", v, 8'h11);

        // R9: odd/even steering
        load_planes(BASE + 20'h6, 8'h55, 8'h55, 8'h55, 8'h55);
        load_planes(BASE + 20'h3, 8'h00, 8'h00, 8'h00, 8'h00);
        cfg_seq_linear = 1'b0;
        wr(BASE + 20'h6, 8'hE1);
        wr(BASE + 20'h7, 8'h7E);
        cfg_default();
        for (int p = 0; p < 4; p++) begin
            rd_plane(BASE + 20'h3, 2'(p), v);
            chk("R9 odd/even plane", v, (p % 2 == 0) ? 8'hE1 : 8'h7E);
        end
        rd_plane(BASE + 20'h6, 2'd0, v);
        chk("R9 unshifted offset untouched", v, 8'h55);

        // R10: plane select and all latches loaded by one read
        load_planes(BASE + 20'h50, 8'hC1, 8'hC2, 8'hC3, 8'hC4);
        rd_plane(BASE + 20'h50, 2'd2, v);
        chk("R10 read plane 2", v, 8'hC3);
        cfg_write_mode = 2'd1;
        wr(BASE + 20'h51, 8'h00);
        cfg_default();
        for (int p = 0; p < 4; p++) begin
            rd_plane(BASE + 20'h51, 2'(p), v);
            chk("R10 latch load", v, 8'hC1 + 8'(p));
        end

        // R11: chain-4 read
        load_planes(BASE + 20'h5, 8'h1A, 8'h2B, 8'h3C, 8'h4D);
        cfg_chain4 = 1'b1;
        rd_plane(BASE + 20'h16, 2'd0, v);
        chk("R11 chain4 plane 2", v, 8'h3C);
        rd_plane(BASE + 20'h17, 2'd0, v);
        chk("R11 chain4 plane 3", v, 8'h4D);
        cfg_chain4 = 1'b0;
        cfg_write_mode = 2'd1;
        wr(BASE + 20'h60, 8'h00);
        cfg_default();
        rd_plane(BASE + 20'h60, 2'd1, v);
        chk("R11 chain4 latch load", v, 8'h2B);

        // R12: offset wraps at the effective window size
        cfg_default();
        wr(BASE + 20'h209, 8'h6B);
        rd_plane(BASE + 20'h9, 2'd1, v);
        chk("R12 window wrap", v, 8'h6B);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule